// File: doc/BRIEF.md
# Dual-Chain LCD Segment/Common Driver Core

This block is the digital heart of a 40-output dot-matrix LCD driver. It holds two 20-stage serial shift chains, and each chain loads a 20-bit hold latch. A controller clocks display bits in through a slow shift strobe and then transfers them into the latches with a slow latch strobe. Each latched bit, together with the frame alternation input, selects one of six bias rails. Every output carries that choice as a 3-bit rail code, and an analog stage outside this block turns the code into a panel voltage.

The first chain always works as a column (segment) driver. A mode input decides what the second chain does. It can be a second column driver that uses the same strobes as the first. It can also be a row (common) driver, in which case it shifts and loads on the opposite strobes, on their rising edges, and uses a different rail mapping. Each chain has a direction bit that sets which way data travels. The same bit decides which pin of its left/right serial pair is the input and which is the output.

The strobes, the alternation signal, the mode input and the serial inputs are slow, asynchronous signals. A two-flop stage brings them into the fast system clock domain, and strobe edges are detected there.

Top module: `lcd_drv_core`

## Requirements
- R1: A synchronous reset clears both shift chains and both latches to zero. After reset, with alternation 0 and mode 0, outputs 1-20 carry code 4 and outputs 21-40 carry code 6.
- R2: When a chain's direction bit is 0, a shift takes the left serial input into the stage of the lowest-numbered output, and every stage moves one place toward the higher-numbered outputs. After 20 shifts, the first bit fed in sits at the chain's highest output.
- R3: When a chain's direction bit is 1, a shift takes the right serial input into the stage of the highest-numbered output, and data moves toward the lower-numbered outputs.
- R4: Chain 1 shifts on each falling edge of the shift strobe and loads its latch on each falling edge of the latch strobe. Rising edges of either strobe leave chain 1 and its latch unchanged.
- R5: With mode 0, chain 2 shifts and loads on the same strobe edges as chain 1.
- R6: With mode 1, chain 2 shifts on the rising edge of the latch strobe and loads its latch on the rising edge of the shift strobe. Falling edges leave chain 2 unchanged.
- R7: The code of a chain 1 output is 1 for latched 1 with alternation 1, 2 for latched 1 with alternation 0, 3 for latched 0 with alternation 1, and 4 for latched 0 with alternation 0.
- R8: With mode 0, the code of a chain 2 output is 1 for latched 1 with alternation 1, 2 for latched 1 with alternation 0, 5 for latched 0 with alternation 1, and 6 for latched 0 with alternation 0.
- R9: With mode 1, the code of a chain 2 output is 2 for latched 1 with alternation 1, 1 for latched 1 with alternation 0, 6 for latched 0 with alternation 1, and 5 for latched 0 with alternation 0.
- R10: With direction 0, the right pin of a chain is enabled and drives the stage of the chain's highest output, while the left pin is disabled and drives 0. With direction 1 the roles swap, and the left pin drives the stage of the lowest output.
- R11: Output n (1 to 40) takes bits [3n-1:3n-3] of the level bus. Outputs 1-20 belong to chain 1 and outputs 21-40 to chain 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cl1_in | input | 1 | Latch strobe (row shift strobe in common mode) |
| cl2_in | input | 1 | Shift strobe (row load strobe in common mode) |
| alt_m | input | 1 | Frame alternation |
| mode_com | input | 1 | 1: chain 2 is a common driver |
| dir1 | input | 1 | Chain 1 direction |
| dir2 | input | 1 | Chain 2 direction |
| ser1_l_in | input | 1 | Chain 1 left pin, input side |
| ser1_r_in | input | 1 | Chain 1 right pin, input side |
| ser2_l_in | input | 1 | Chain 2 left pin, input side |
| ser2_r_in | input | 1 | Chain 2 right pin, input side |
| ser1_l_out | output | 1 | Chain 1 left pin, output side |
| ser1_l_oe | output | 1 | Chain 1 left pin output enable |
| ser1_r_out | output | 1 | Chain 1 right pin, output side |
| ser1_r_oe | output | 1 | Chain 1 right pin output enable |
| ser2_l_out | output | 1 | Chain 2 left pin, output side |
| ser2_l_oe | output | 1 | Chain 2 left pin output enable |
| ser2_r_out | output | 1 | Chain 2 right pin, output side |
| ser2_r_oe | output | 1 | Chain 2 right pin output enable |
| lvl_out | output | 120 | 40 packed 3-bit rail codes |

## Verification
A strobe or serial-input change passes through the two synchronizer flops and then the edge-history register. The shift stage or latch therefore changes on the third system-clock edge after the input moves, and the rail codes and serial pins follow in that same cycle. A change of alternation reaches the codes after two edges, since it only passes the synchronizer. A change of direction acts at once on the pin enables. The bench changes one input at a time, updates its model at that moment, then waits six cycles and samples at the falling clock edge, so every result is due well before the sample is taken.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

   localparam int RAIL_W = 3;

   typedef enum logic [RAIL_W-1:0] {
      RAIL_NONE = 3'd0,
      RAIL_V1   = 3'd1,
      RAIL_V2   = 3'd2,
      RAIL_V3   = 3'd3,
      RAIL_V4   = 3'd4,
      RAIL_V5   = 3'd5,
      RAIL_V6   = 3'd6
   } rail_e;

   // Select rail: a set bit picks V1/V2, a clear bit picks the chain's
   // non-select pair. The swap flag inverts the alternation phase.
   function automatic rail_e pick_rail(input logic d, input logic m,
                                       input logic swap,
                                       input rail_e off_hi,
                                       input rail_e off_lo);
      logic ph;
      ph = m ^ swap;
      if (d) return ph ? RAIL_V1 : RAIL_V2;
      return ph ? off_hi : off_lo;
   endfunction

endpackage

// File: rtl/lcd_drv_sync.sv
module lcd_drv_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int TOT = W * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("lcd_drv_sync needs at least two stages");
   end

   logic [TOT-1:0] pipe;

   always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[TOT-W-1:0], d};
   end

   assign q = pipe[TOT-1 -: W];
endmodule

// File: rtl/lcd_drv_edge.sv
module lcd_drv_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);
   logic [N-1:0] prev;

   always_ff @(posedge clk) begin
      if (rst) prev <= '0;
      else     prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/lcd_drv_chain.sv
module lcd_drv_chain #(
   parameter int LEN = 20
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift_en,
   input  logic           latch_en,
   input  logic           dir,
   input  logic           in_l,
   input  logic           in_r,
   output logic           out_l,
   output logic           out_r,
   output logic           oe_l,
   output logic           oe_r,
   output logic [LEN-1:0] latched
);
   if (LEN < 2) begin : g_bad_len
      $error("lcd_drv_chain needs at least two stages");
   end

   logic [LEN-1:0] sr;

   always_ff @(posedge clk) begin
      if (rst) begin
         sr <= '0;
      end else if (shift_en) begin
         if (!dir) sr <= {sr[LEN-2:0], in_l};
         else      sr <= {in_r, sr[LEN-1:1]};
      end
   end

   always_ff @(posedge clk) begin
      if (rst)           latched <= '0;
      else if (latch_en) latched <= sr;
   end

   assign oe_l  = dir;
   assign oe_r  = ~dir;
   assign out_l = dir & sr[0];
   assign out_r = ~dir & sr[LEN-1];
endmodule

// File: rtl/lcd_drv_levmap.sv
module lcd_drv_levmap
   import lcd_drv_pkg::*;
#(
   parameter int    LEN    = 20,
   parameter rail_e OFF_HI = RAIL_V3,
   parameter rail_e OFF_LO = RAIL_V4
) (
   input  logic [LEN-1:0]        latched,
   input  logic                  m,
   input  logic                  swap,
   output logic [LEN*RAIL_W-1:0] codes
);
   for (genvar i = 0; i < LEN; i++) begin : g_ch
      assign codes[i*RAIL_W +: RAIL_W] =
         pick_rail(latched[i], m, swap, OFF_HI, OFF_LO);
   end
endmodule

// File: rtl/lcd_drv_core.sv
module lcd_drv_core
   import lcd_drv_pkg::*;
#(
   parameter int CHAIN_LEN   = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cl1_in,
   input  logic                         cl2_in,
   input  logic                         alt_m,
   input  logic                         mode_com,
   input  logic                         dir1,
   input  logic                         dir2,
   input  logic                         ser1_l_in,
   input  logic                         ser1_r_in,
   input  logic                         ser2_l_in,
   input  logic                         ser2_r_in,
   output logic                         ser1_l_out,
   output logic                         ser1_l_oe,
   output logic                         ser1_r_out,
   output logic                         ser1_r_oe,
   output logic                         ser2_l_out,
   output logic                         ser2_l_oe,
   output logic                         ser2_r_out,
   output logic                         ser2_r_oe,
   output logic [2*CHAIN_LEN*3-1:0]     lvl_out
);
   localparam int NUM_OUT = 2 * CHAIN_LEN;
   localparam int BUS_W   = CHAIN_LEN * RAIL_W;
   localparam int IN_W    = 8;

   if (RAIL_W != 3) begin : g_bad_rail
      $error("level bus assumes 3-bit rail codes");
   end
   if (NUM_OUT * RAIL_W != $bits(lvl_out)) begin : g_bad_bus
      $error("level bus width mismatch");
   end

   logic [IN_W-1:0] raw_in, syn;
   logic cl1_s, cl2_s, m_s, mode_s;
   logic s1l, s1r, s2l, s2r;
   logic [1:0] rise, fall;
   logic c1_shift, c1_latch, c2_shift, c2_latch;
   logic [CHAIN_LEN-1:0] lat1, lat2;
   logic [BUS_W-1:0] codes1, codes2;

   assign raw_in = {ser2_r_in, ser2_l_in, ser1_r_in, ser1_l_in,
                    mode_com, alt_m, cl2_in, cl1_in};

   lcd_drv_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(raw_in), .q(syn));

   assign {s2r, s2l, s1r, s1l, mode_s, m_s, cl2_s, cl1_s} = syn;

   lcd_drv_edge #(.N(2)) u_edge (
      .clk(clk), .rst(rst), .lvl({cl2_s, cl1_s}), .rise(rise), .fall(fall));

   // index 0: latch strobe, index 1: shift strobe
   assign c1_shift = fall[1];
   assign c1_latch = fall[0];
   assign c2_shift = mode_s ? rise[0] : fall[1];
   assign c2_latch = mode_s ? rise[1] : fall[0];

   lcd_drv_chain #(.LEN(CHAIN_LEN)) u_chain1 (
      .clk(clk), .rst(rst), .shift_en(c1_shift), .latch_en(c1_latch),
      .dir(dir1), .in_l(s1l), .in_r(s1r),
      .out_l(ser1_l_out), .out_r(ser1_r_out),
      .oe_l(ser1_l_oe), .oe_r(ser1_r_oe), .latched(lat1));

   lcd_drv_chain #(.LEN(CHAIN_LEN)) u_chain2 (
      .clk(clk), .rst(rst), .shift_en(c2_shift), .latch_en(c2_latch),
      .dir(dir2), .in_l(s2l), .in_r(s2r),
      .out_l(ser2_l_out), .out_r(ser2_r_out),
      .oe_l(ser2_l_oe), .oe_r(ser2_r_oe), .latched(lat2));

   lcd_drv_levmap #(.LEN(CHAIN_LEN), .OFF_HI(RAIL_V3), .OFF_LO(RAIL_V4))
   u_map1 (.latched(lat1), .m(m_s), .swap(1'b0), .codes(codes1));

   lcd_drv_levmap #(.LEN(CHAIN_LEN), .OFF_HI(RAIL_V5), .OFF_LO(RAIL_V6))
   u_map2 (.latched(lat2), .m(m_s), .swap(mode_s), .codes(codes2));

   assign lvl_out = {codes2, codes1};
endmodule

// File: rtl/lcd_drv_core_chk.sv
module lcd_drv_core_chk #(
   parameter int LEN = 20
) (
   input logic               clk,
   input logic               rst,
   input logic               mode_s,
   input logic               c1_latch,
   input logic               c2_latch,
   input logic [LEN-1:0]     lat1,
   input logic [LEN-1:0]     lat2,
   input logic [2*LEN*3-1:0] lvl_out
);
   AST_LAT1_HOLD: assert property (@(posedge clk) disable iff (rst)
      !c1_latch |=> $stable(lat1)); // R4

   AST_LAT2_HOLD: assert property (@(posedge clk) disable iff (rst)
      !c2_latch |=> $stable(lat2)); // R6

   AST_RST_CLEAR: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (lat1 == '0 && lat2 == '0)); // R1

   for (genvar i = 0; i < LEN; i++) begin : g_ch
      AST_C1_SEL: assert property (@(posedge clk) disable iff (rst)
         lat1[i] |-> (lvl_out[i*3 +: 3] == 3'd1 || lvl_out[i*3 +: 3] == 3'd2)); // R7
      AST_C1_NSEL: assert property (@(posedge clk) disable iff (rst)
         !lat1[i] |-> (lvl_out[i*3 +: 3] == 3'd3 || lvl_out[i*3 +: 3] == 3'd4)); // R7
      AST_C2_NSEL_SEG: assert property (@(posedge clk) disable iff (rst)
         (!lat2[i] && !mode_s) |-> (lvl_out[(LEN+i)*3 +: 3] == 3'd5 ||
                                    lvl_out[(LEN+i)*3 +: 3] == 3'd6)); // R8
      AST_C2_SEL_COM: assert property (@(posedge clk) disable iff (rst)
         (lat2[i] && mode_s) |-> (lvl_out[(LEN+i)*3 +: 3] == 3'd1 ||
                                  lvl_out[(LEN+i)*3 +: 3] == 3'd2)); // R9
   end
endmodule

bind lcd_drv_core lcd_drv_core_chk #(.LEN(CHAIN_LEN)) u_chk (
   .clk(clk), .rst(rst), .mode_s(mode_s), .c1_latch(c1_latch),
   .c2_latch(c2_latch), .lat1(lat1), .lat2(lat2), .lvl_out(lvl_out));

// File: tb/sim_lcd_drv_core.sv
module sim_lcd_drv_core;
   localparam int LEN = 20;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cl1_in = 0, cl2_in = 0, alt_m = 0, mode_com = 0, dir1 = 0, dir2 = 0;
   logic ser1_l_in = 0, ser1_r_in = 0, ser2_l_in = 0, ser2_r_in = 0;
   logic ser1_l_out, ser1_l_oe, ser1_r_out, ser1_r_oe;
   logic ser2_l_out, ser2_l_oe, ser2_r_out, ser2_r_oe;
   logic [2*LEN*3-1:0] lvl_out;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   bit sr1 [LEN];
   bit sr2 [LEN];
   bit lt1 [LEN];
   bit lt2 [LEN];

   always #2.5 clk = ~clk;

   lcd_drv_core u0 (
      .clk(clk), .rst(rst), .cl1_in(cl1_in), .cl2_in(cl2_in), .alt_m(alt_m),
      .mode_com(mode_com), .dir1(dir1), .dir2(dir2),
      .ser1_l_in(ser1_l_in), .ser1_r_in(ser1_r_in),
      .ser2_l_in(ser2_l_in), .ser2_r_in(ser2_r_in),
      .ser1_l_out(ser1_l_out), .ser1_l_oe(ser1_l_oe),
      .ser1_r_out(ser1_r_out), .ser1_r_oe(ser1_r_oe),
      .ser2_l_out(ser2_l_out), .ser2_l_oe(ser2_l_oe),
      .ser2_r_out(ser2_r_out), .ser2_r_oe(ser2_r_oe),
      .lvl_out(lvl_out));

   function automatic int exp_code(bit chain2, bit d, bit m, bit com);
      if (!chain2) return d ? (m ? 1 : 2) : (m ? 3 : 4);
      if (!com)    return d ? (m ? 1 : 2) : (m ? 5 : 6);
      return d ? (m ? 2 : 1) : (m ? 6 : 5);
   endfunction

   function automatic int code_at(int n); // n = 1..40 (R11)
      return int'(lvl_out[3*(n-1) +: 3]);
   endfunction

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic check_val(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      int err_n = 0;
      int fa = 0, fe = 0;
      string fw = "";
      for (int n = 1; n <= 2*LEN; n++) begin
         int e;
         if (n <= LEN) e = exp_code(0, lt1[n-1], alt_m, mode_com);
         else          e = exp_code(1, lt2[n-LEN-1], alt_m, mode_com);
         if (code_at(n) != e) begin
            if (err_n == 0) begin fa = code_at(n); fe = e; fw = $sformatf("out%0d", n); end
            err_n++;
         end
      end
      begin
         int a = {ser1_l_oe, ser1_l_out, ser1_r_oe, ser1_r_out,
                  ser2_l_oe, ser2_l_out, ser2_r_oe, ser2_r_out};
         int x = {dir1, dir1 & sr1[0], !dir1, !dir1 & sr1[LEN-1],
                  dir2, dir2 & sr2[0], !dir2, !dir2 & sr2[LEN-1]};
         if (a != x && err_n == 0) begin fa = a; fe = x; fw = "serial pins (R10)"; end
         if (a != x) err_n++;
      end
      total++;
      if (err_n != 0) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, fw, fa, fe);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic shift_model(bit c2);
      if (!c2) begin
         if (!dir1) begin
            for (int i = LEN-1; i > 0; i--) sr1[i] = sr1[i-1];
            sr1[0] = ser1_l_in;
         end else begin
            for (int i = 0; i < LEN-1; i++) sr1[i] = sr1[i+1];
            sr1[LEN-1] = ser1_r_in;
         end
      end else begin
         if (!dir2) begin
            for (int i = LEN-1; i > 0; i--) sr2[i] = sr2[i-1];
            sr2[0] = ser2_l_in;
         end else begin
            for (int i = 0; i < LEN-1; i++) sr2[i] = sr2[i+1];
            sr2[LEN-1] = ser2_r_in;
         end
      end
   endtask

   // R4 R5 R6: which edges act on which chain
   task automatic model_edge(bit is_cl1, bit rising);
      if (!is_cl1 && !rising) shift_model(0);
      if (is_cl1 && !rising) for (int i = 0; i < LEN; i++) lt1[i] = sr1[i];
      if (!mode_com) begin
         if (!is_cl1 && !rising) shift_model(1);
         if (is_cl1 && !rising) for (int i = 0; i < LEN; i++) lt2[i] = sr2[i];
      end else begin
         if (is_cl1 && rising) shift_model(1);
         if (!is_cl1 && rising) for (int i = 0; i < LEN; i++) lt2[i] = sr2[i];
      end
   endtask

   task automatic tog_cl1();
      cl1_in = ~cl1_in;
      model_edge(1, cl1_in);
      settle();
   endtask

   task automatic tog_cl2();
      cl2_in = ~cl2_in;
      model_edge(0, cl2_in);
      settle();
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      void'($urandom(32'd20240613));
      for (int i = 0; i < LEN; i++) begin sr1[i] = 0; sr2[i] = 0; lt1[i] = 0; lt2[i] = 0; end
      repeat (4) @(negedge clk);
      rst = 0;
      settle();
      // R1: reset state
      check_all("R1");
      check_val("R1", "out1", code_at(1), 4);
      check_val("R1", "out21", code_at(21), 6);

      // R2: direction 0, single 1 walks to output 20
      alt_m = 1; settle();
      for (int k = 0; k < LEN; k++) begin
         ser1_l_in = (k == 0); settle();
         tog_cl2(); tog_cl2();
      end
      ser1_l_in = 0;
      tog_cl1(); tog_cl1();
      check_val("R2", "out20", code_at(20), 1);
      check_val("R2", "out1", code_at(1), 3);
      check_all("R2/R10");

      // R3: direction 1, single 1 walks to output 1
      dir1 = 1; settle();
      for (int k = 0; k < LEN; k++) begin
         ser1_r_in = (k == 0); settle();
         tog_cl2(); tog_cl2();
      end
      ser1_r_in = 0;
      tog_cl1(); tog_cl1();
      check_val("R3", "out1", code_at(1), 1);
      check_val("R3", "out20", code_at(20), 3);
      check_all("R3/R10");

      // R4/R5: rising edges alone change nothing in segment mode
      ser1_r_in = 1; ser2_l_in = 1; settle();
      tog_cl2(); tog_cl1();
      check_all("R4/R5");

      // R6/R9: common mode, chain 2 shifts on latch-strobe rise
      tog_cl2(); tog_cl1();
      mode_com = 1; alt_m = 0; settle();
      for (int k = 0; k < LEN; k++) begin
         ser2_l_in = k[0]; settle();
         tog_cl1(); tog_cl1();
      end
      tog_cl2(); tog_cl2();
      check_val("R6", "out40", code_at(40), exp_code(1, 1'b0, 1'b0, 1'b1));
      check_val("R9", "out39", code_at(39), 1);
      check_all("R6/R9");

      // mixed random stimulus
      for (int it = 0; it < 400; it++) begin
         int r = int'($urandom % 8);
         case (r)
            0, 1: tog_cl1();
            2, 3: tog_cl2();
            4: begin alt_m = ~alt_m; settle(); end
            5: begin
               {ser1_l_in, ser1_r_in, ser2_l_in, ser2_r_in} = 4'($urandom);
               settle();
            end
            6: begin {dir1, dir2} = 2'($urandom); settle(); end
            default: begin
               if ($urandom % 4 == 0) begin mode_com = ~mode_com; settle(); end
               else tog_cl2();
            end
         endcase
         check_all("R4/R5/R6/R7/R8/R9/R10/R11");
      end
      finish_up();
   end
endmodule